// File: doc/BRIEF.md
# Two-Wire Clock/Calendar Register Slave with Power-Fail Lockout

This block is the serial-bus side of a clock/calendar device. It watches the two bus lines, SCL and SDA, through synchronizers clocked by a faster system clock. It answers to one fixed 7-bit device address and gives a bus master read and write access to a bank of twenty byte registers. The bank is reached through an address pointer that advances on every byte moved. The registers hold, in pointer order, the sub-second count, seconds, minutes, hours with century, weekday, day of month, month, year, calibration, watchdog, five alarm bytes, flags, three spare bytes and the square-wave control. The block itself only stores the bytes. It does not interpret them.

A write transfer sends the device address with the direction bit clear. The first byte after it sets the pointer, and every later byte is stored and advances the pointer. A read transfer sends the address with the direction bit set. The slave then returns bytes from the current pointer until the master withholds its acknowledge. SDA is driven only low, through an open-drain enable output.

A power-fail input overrides the bus. While it is high, the slave releases SDA, abandons any transfer, clears the pointer and ignores every bus event. This keeps a failing supply from corrupting the bank. Once power-fail drops, the slave answers again from the next start condition.

Top module: `rtc_regbus_slave`

## Requirements
- R1: Only an address byte whose upper seven bits equal 0x68 (0xD0 for write, 0xD1 for read, direction in bit 0) is acknowledged. Any other address gets no acknowledge, and the slave stays off the bus until the next start.
- R2: The slave acknowledges the matched address byte, the pointer byte and every written data byte by asserting sda_oe (SDA pulled low) through the ninth SCL pulse.
- R3: The first byte after a write address loads the pointer. A value of 20 or more loads 0.
- R4: Each later written byte is stored in the register selected by the pointer, and the pointer then advances by one.
- R5: After a read address, the slave sends the register at the pointer MSB first, and the pointer advances for each byte sent. A master acknowledge (SDA low on the ninth pulse) requests another byte. A master non-acknowledge makes the slave release SDA and stop transmitting, and the pointer still advances past the byte that was not acknowledged.
- R6: The pointer steps from 19 to 0 and never holds a value above 19.
- R7: An SDA fall while SCL is high is a start condition. It begins a new address byte at any point, including in the middle of a transfer. An SDA rise while SCL is high is a stop condition, which ends the transfer. A byte cut off by a stop is not stored.
- R8: When pwr_fail is high, sda_oe is low from the next clock, the transfer in progress is dropped without storing its partial byte, and the pointer is 0.
- R9: While pwr_fail is high, no start, address or data on the bus has any effect. There is no acknowledge and no register write. After pwr_fail falls, the slave responds from the next start condition.
- R10: After reset all twenty registers read 0, the pointer is 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_fail | input | 1 | High while the supply is out of tolerance; locks out the bus |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |

## Verification
The hardest case to reach from the ports is a power failure that lands in the middle of a data byte. The master then keeps clocking the rest of that byte after power returns, and the slave must ignore those clocks. To get there, the bench bit-bangs half of a data byte, raises pwr_fail for several SCL-quarter periods, drops it, and clocks out the remaining bits and the acknowledge slot. It then checks three things: no acknowledge appeared, the target register kept its earlier value, and a read without a pointer byte returns register 0. A second sequence holds pwr_fail high for a whole well-formed write and checks that nothing was acknowledged or stored.

// File: rtl/rtc_regbus_slave.sv
module rtc_regbus_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int         NREGS    = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_fail,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int PW = $clog2(NREGS);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_TXACK} st_t;
  localparam logic [1:0] M_ADDR = 2'd0, M_PTR = 2'd1, M_DATA = 2'd2;

  logic [2:0]    scl_sy, sda_sy;
  st_t           state;
  logic [1:0]    mode;
  logic [3:0]    bitcnt;
  logic [7:0]    sh;
  logic          rw, mack;
  logic [PW-1:0] ptr;
  logic [7:0]    regs [NREGS];

  wire scl      = scl_sy[1];
  wire sda      = sda_sy[1];
  wire scl_rise = scl & ~scl_sy[2];
  wire scl_fall = ~scl & scl_sy[2];
  wire start_c  = scl & scl_sy[2] & sda_sy[2] & ~sda;
  wire stop_c   = scl & scl_sy[2] & ~sda_sy[2] & sda;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(NREGS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      mode   <= M_ADDR;
      bitcnt <= '0;
      sh     <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      ptr    <= '0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (pwr_fail) begin
      state  <= S_IDLE;
      ptr    <= '0;
      sda_oe <= 1'b0;
      bitcnt <= '0;
    end else if (start_c) begin
      state  <= S_RX;
      mode   <= M_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      state  <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        S_RX: begin
          if (scl_rise) begin
            sh     <= {sh[6:0], sda};
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            case (mode)
              M_ADDR: begin
                if (sh[7:1] == DEV_ADDR) begin
                  rw     <= sh[0];
                  sda_oe <= 1'b1;
                  state  <= S_ACK;
                end else begin
                  state  <= S_IDLE;
                end
              end
              M_PTR: begin
                ptr    <= (sh < NREGS) ? sh[PW-1:0] : '0;
                sda_oe <= 1'b1;
                state  <= S_ACK;
              end
              default: begin
                regs[ptr] <= sh;
                ptr       <= nxt(ptr);
                sda_oe    <= 1'b1;
                state     <= S_ACK;
              end
            endcase
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (mode == M_ADDR && rw) begin
              state  <= S_TX;
              sh     <= regs[ptr];
              sda_oe <= ~regs[ptr][7];
              ptr    <= nxt(ptr);
            end else begin
              state  <= S_RX;
              mode   <= (mode == M_ADDR) ? M_PTR : M_DATA;
              sda_oe <= 1'b0;
            end
          end
        end
        S_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              state  <= S_TXACK;
            end else begin
              sh     <= {sh[6:0], 1'b0};
              sda_oe <= ~sh[6];
            end
          end
        end
        S_TXACK: begin
          if (scl_rise) begin
            mack <= ~sda;
          end else if (scl_fall) begin
            bitcnt <= '0;
            if (mack) begin
              state  <= S_TX;
              sh     <= regs[ptr];
              sda_oe <= ~regs[ptr][7];
              ptr    <= nxt(ptr);
            end else begin
              state  <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

module rtc_regbus_slave_chk #(
  parameter int NREGS = 20,
  parameter int PW    = $clog2(NREGS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_fail,
  input logic          sda_oe,
  input logic [2:0]    st,
  input logic [PW-1:0] ptr
);
  assert_pf_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> !sda_oe);
  assert_pf_ptr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> ptr == '0);
  assert_ptr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr < PW'(NREGS));
  assert_no_drive_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(!pwr_fail));
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0) |-> !sda_oe);
endmodule

bind rtc_regbus_slave rtc_regbus_slave_chk #(.NREGS(NREGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .sda_oe(sda_oe),
  .st(state), .ptr(ptr)
);

// File: tb/rtc_regbus_slave_bench.sv
module rtc_regbus_slave_bench;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_fail = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  wire  sda_bus = m_sda & ~sda_oe;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rtc_regbus_slave u_rtc_regbus_slave (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail),
    .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe)
  );

  // {pointer, value} pairs written then read back
  localparam logic [15:0] VEC [6] = '{
    {8'd1,  8'hA5}, {8'd7,  8'h3C}, {8'd12, 8'h96},
    {8'd16, 8'h0F}, {8'd19, 8'hE1}, {8'd3,  8'h42}
  };

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b1; wq();
  endtask

  task automatic clk_bit(input logic b, output logic r);
    m_sda = b; wq();
    m_scl = 1'b1; wq();
    r = sda_bus; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      v[i] = r;
    end
    clk_bit(~give_ack, r);
  endtask

  task automatic wr_reg(input logic [7:0] p, input logic [7:0] v);
    logic a;
    bus_start();
    wr_byte(8'hD0, a); chk("R2 addr ack", {7'd0, a}, 8'd1);
    wr_byte(p, a);     chk("R2 ptr ack", {7'd0, a}, 8'd1);
    wr_byte(v, a);     chk("R2 data ack", {7'd0, a}, 8'd1);
    bus_stop();
  endtask

  task automatic rd_at(input logic [7:0] p, output logic [7:0] v);
    logic a;
    bus_start();
    wr_byte(8'hD0, a);
    wr_byte(p, a);
    bus_start();
    wr_byte(8'hD1, a); chk("R1 read addr ack", {7'd0, a}, 8'd1);
    rd_byte(1'b0, v);
    bus_stop();
  endtask

  task automatic rd_cur(output logic [7:0] v, output logic a);
    bus_start();
    wr_byte(8'hD1, a);
    rd_byte(1'b0, v);
    bus_stop();
  endtask

  initial begin
    logic [7:0] v;
    logic a, r;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wq();

    // R10 reset state
    chk("R10 sda released", {7'd0, sda_oe}, 8'd0);
    rd_cur(v, a);
    chk("R10 ack after reset", {7'd0, a}, 8'd1);
    chk("R10 reg0 zero", v, 8'h00);
    rd_at(8'd19, v);
    chk("R10 reg19 zero", v, 8'h00);

    // R1 foreign address
    bus_start();
    wr_byte(8'hA0, a);
    chk("R1 foreign no ack", {7'd0, a}, 8'd0);
    wr_byte(8'h05, a);
    chk("R1 stays off bus", {7'd0, a}, 8'd0);
    bus_stop();

    // R4 vector table
    for (int i = 0; i < 6; i++) begin
      wr_reg(VEC[i][15:8], VEC[i][7:0]);
      rd_at(VEC[i][15:8], v);
      chk("R4 readback", v, VEC[i][7:0]);
    end

    // R6 burst wrap, R5 burst read
    bus_start();
    wr_byte(8'hD0, a);
    wr_byte(8'd18, a);
    wr_byte(8'h11, a); chk("R2 burst ack", {7'd0, a}, 8'd1);
    wr_byte(8'h22, a);
    wr_byte(8'h33, a);
    bus_stop();
    bus_start();
    wr_byte(8'hD0, a);
    wr_byte(8'd18, a);
    bus_start();
    wr_byte(8'hD1, a);
    rd_byte(1'b1, v); chk("R5 burst byte 18", v, 8'h11);
    rd_byte(1'b1, v); chk("R5 burst byte 19", v, 8'h22);
    rd_byte(1'b0, v); chk("R6 wrap to reg0", v, 8'h33);
    wq();
    chk("R5 released after nack", {7'd0, sda_oe}, 8'd0);
    bus_stop();
    rd_cur(v, a);
    chk("R5 pointer past nacked byte", v, 8'hA5);

    // R3 out-of-range pointer loads 0
    wr_reg(8'd25, 8'h5A);
    rd_at(8'd0, v);
    chk("R3 ptr>=20 to 0", v, 8'h5A);

    // R7 stop inside a byte discards it
    bus_start();
    wr_byte(8'hD0, a);
    wr_byte(8'd16, a);
    for (int i = 0; i < 4; i++) clk_bit(1'b1, r);
    bus_stop();
    rd_at(8'd16, v);
    chk("R7 partial byte dropped", v, 8'h0F);

    // R8 power fail mid data byte
    bus_start();
    wr_byte(8'hD0, a);
    wr_byte(8'd7, a);
    clk_bit(1'b1, r); clk_bit(1'b1, r); clk_bit(1'b0, r); clk_bit(1'b0, r);
    pwr_fail = 1'b1;
    wq();
    chk("R8 sda released", {7'd0, sda_oe}, 8'd0);
    wq(); wq();
    pwr_fail = 1'b0;
    clk_bit(1'b0, r); clk_bit(1'b0, r); clk_bit(1'b1, r); clk_bit(1'b1, r);
    clk_bit(1'b1, r);
    chk("R8 no ack after abort", {7'd0, ~r}, 8'd0);
    bus_stop();
    rd_cur(v, a);
    chk("R8 pointer reset", v, 8'h5A);
    rd_at(8'd7, v);
    chk("R8 reg kept", v, 8'h3C);

    // R9 whole write under lockout
    pwr_fail = 1'b1;
    wq();
    bus_start();
    wr_byte(8'hD0, a);
    chk("R9 no ack locked", {7'd0, a}, 8'd0);
    wr_byte(8'd3, a);
    wr_byte(8'hEE, a);
    chk("R9 no data ack", {7'd0, a}, 8'd0);
    bus_stop();
    pwr_fail = 1'b0;
    wq();
    rd_at(8'd3, v);
    chk("R9 reg unchanged", v, 8'h42);
    rd_cur(v, a);
    chk("R9 responds after release", {7'd0, a}, 8'd1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule